// File: doc/BRIEF.md
# I2C Bus Monitor with Arbitration Guard

This block sits beside a local I2C master engine and watches the two bus lines after they have been brought into the system clock domain. It recognises START and STOP conditions and keeps a bus-busy state. While the local master owns the bus and is driving address or data bits, it compares every bit the master leaves released with the level seen on SDA when SCL rises. If the master releases a 1 but the line reads 0, arbitration is lost. The block then tells the engine to release both lines until the bus goes idle, raises a sticky arbitration-error flag and a sticky transmit-lockout flag, pulses a transmit-queue flush request, and clears every pending START, RESTART and STOP request.

Software asks for a START through a request pulse. The block holds the request while the bus is busy. After the other master's STOP, it waits a bus-free time equal to the programmed SCL low count before it signals the engine to drive its START. The block also decodes the first byte after every START. When another master sends this device's own 7-bit address, master mode drops and the device becomes a slave. This also happens when arbitration was lost inside that same address byte. A loss alone leaves master mode set.

Top module: `i2c_arb_monitor`

## Requirements
- R1: After reset, busBusy, startGo, backOff, flushReq, arbErr, txLockout, masterMode and all three request flags are 0.
- R2: START (SDA falls while SCL high) sets busBusy and STOP (SDA rises while SCL high) clears it, each within three clock cycles of the line change.
- R3: When the local master owns the bus, mstTxActive is 1 and mstSdaOut is 1 (1 means released), a rising SCL with SDA sampled 0 counts as a lost arbitration. This sets arbErr and txLockout and gives exactly one one-cycle flushReq pulse.
- R4: No loss is flagged when the master drives 0, when the line matches a released 1, or when mstTxActive is 0.
- R5: On a loss, startPend, restartPend and stopPend are cleared, and backOff stays 1 until the next STOP.
- R6: Arbitration loss leaves masterMode at 1. It is cleared only when the first 7 bits after a START (MSB first) equal ownAddr and this device does not own the bus. This includes a loss on the eighth (R/W) bit of that same byte.
- R7: startGo is 0 while the bus is busy. After busBusy falls, startGo rises exactly sclLowTime cycles later if a START is pending in master mode.
- R8: txLockout stays 1 until lockClr, and txPushOk equals txPush while txLockout is 0 and is 0 while txLockout is 1.
- R9: arbErrClr clears arbErr. A loss in the same cycle wins.
- R10: startPend clears at the STOP that ends a transfer owned by this device, and restartPend clears when that device's repeated START appears on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| ownAddr | input | 7 | This device's slave address |
| sclLowTime | input | 16 | SCL low count in clocks, also the bus-free wait |
| mstTxActive | input | 1 | Local master is driving the current address/data bit |
| mstSdaOut | input | 1 | Bit the local master drives (1 = released) |
| masterSet | input | 1 | Pulse: enter master mode |
| startSet | input | 1 | Pulse: request START |
| restartSet | input | 1 | Pulse: request repeated START |
| stopSet | input | 1 | Pulse: request STOP |
| arbErrClr | input | 1 | Pulse: clear arbitration error |
| lockClr | input | 1 | Pulse: clear transmit lockout |
| txPush | input | 1 | Transmit data write attempt |
| txPushOk | output | 1 | Write accepted (not locked out) |
| busBusy | output | 1 | Bus between START and STOP |
| startGo | output | 1 | Engine may drive START now |
| backOff | output | 1 | Lines released after a loss, until STOP |
| flushReq | output | 1 | One-cycle transmit-queue flush request |
| arbErr | output | 1 | Sticky arbitration-error flag |
| txLockout | output | 1 | Sticky transmit-lockout flag |
| masterMode | output | 1 | Device is in master mode |
| startPend | output | 1 | START request pending |
| restartPend | output | 1 | Repeated START request pending |
| stopPend | output | 1 | STOP request pending |

## Verification
A wrong ownership or busy state shows up as a startGo pulse while the bus is occupied. It can also show up as a bus-free wait whose length differs from sclLowTime by one or more cycles, and the bench times this window from the fall of busBusy. A wrong bit comparison or a wrong address shift shows up at the end of the byte being sent: a spurious or missing error flag, a flush count off by one, or masterMode in the wrong state. The cases checked include a loss on the final R/W bit, where the address match and the loss occur in the same cycle. Sticky flags and request clearing are read back before the next transfer starts, so any leak into the following transaction is seen within that transaction.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

  // Events decoded by the datapath, consumed by the control.
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclRise;
    logic bitLost;
    logic addrDone;
    logic addrHit;
    logic freeDone;
  } busEv_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadFree;
    logic abortAddr;
  } ctrlStb_t;

endpackage

// File: rtl/i2c_arb_dp.sv
module i2c_arb_dp
  import i2c_arb_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int TIMER_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [ADDR_W-1:0]  ownAddr,
  input  logic [TIMER_W-1:0] sclLowTime,
  input  logic               mstTxActive,
  input  logic               mstSdaOut,
  input  ctrlStb_t           stb,
  output busEv_t             ev
);

  localparam int BYTE_BITS = ADDR_W + 1;
  localparam int BIT_W     = $clog2(BYTE_BITS + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_BITS - 1);

  // Synchronizer chains; idle bus level is high.
  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  logic sclS, sdaS, sclP, sdaP;
  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  logic startDet, stopDet, sclRise;
  assign startDet = sclS && sclP && sdaP && !sdaS;
  assign stopDet  = sclS && sclP && !sdaP && sdaS;
  assign sclRise  = sclS && !sclP;

  // First-byte address capture after every START.
  logic              addrPhase;
  logic [BIT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] addrSh;
  logic              addrDone;

  assign addrDone = addrPhase && sclRise && (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPhase <= 1'b0;
      bitCnt    <= '0;
      addrSh    <= '0;
    end else if (startDet) begin
      addrPhase <= 1'b1;
      bitCnt    <= '0;
    end else if (stopDet || stb.abortAddr) begin
      addrPhase <= 1'b0;
    end else if (addrPhase && sclRise) begin
      if (bitCnt != LAST_BIT) begin
        addrSh <= {addrSh[ADDR_W-2:0], sdaS};
      end
      bitCnt <= bitCnt + 1'b1;
      if (addrDone) addrPhase <= 1'b0;
    end
  end

  // Bus-free countdown, loaded on STOP.
  logic [TIMER_W-1:0] freeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freeCnt <= '0;
    end else if (stb.loadFree) begin
      freeCnt <= sclLowTime;
    end else if (freeCnt != '0) begin
      freeCnt <= freeCnt - 1'b1;
    end
  end

  always_comb begin
    ev          = '0;
    ev.startDet = startDet;
    ev.stopDet  = stopDet;
    ev.sclRise  = sclRise;
    ev.bitLost  = sclRise && mstTxActive && mstSdaOut && !sdaS;
    ev.addrDone = addrDone;
    ev.addrHit  = addrDone && (addrSh == ownAddr);
    ev.freeDone = (freeCnt == '0);
  end

endmodule

// File: rtl/i2c_arb_ctrl.sv
module i2c_arb_ctrl
  import i2c_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  busEv_t   ev,
  input  logic     masterSet,
  input  logic     startSet,
  input  logic     restartSet,
  input  logic     stopSet,
  input  logic     arbErrClr,
  input  logic     lockClr,
  input  logic     txPush,
  output ctrlStb_t stb,
  output logic     txPushOk,
  output logic     busBusy,
  output logic     startGo,
  output logic     backOff,
  output logic     flushReq,
  output logic     arbErr,
  output logic     txLockout,
  output logic     masterMode,
  output logic     startPend,
  output logic     restartPend,
  output logic     stopPend
);

  logic owner, startIssued;
  logic lose, ownerEff, slaveSwitch, clearReq, busFree;

  assign lose        = ev.bitLost && owner && masterMode;
  assign ownerEff    = owner && !lose;
  assign slaveSwitch = ev.addrHit && !ownerEff && masterMode;
  assign clearReq    = lose || slaveSwitch;
  assign busFree     = !busBusy && ev.freeDone;
  assign startGo     = startPend && masterMode && busFree && !startIssued && !owner;
  assign txPushOk    = txPush && !txLockout;

  always_comb begin
    stb           = '0;
    stb.loadFree  = ev.stopDet;
    stb.abortAddr = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busBusy     <= 1'b0;
      owner       <= 1'b0;
      startIssued <= 1'b0;
      backOff     <= 1'b0;
      flushReq    <= 1'b0;
      arbErr      <= 1'b0;
      txLockout   <= 1'b0;
      masterMode  <= 1'b0;
      startPend   <= 1'b0;
      restartPend <= 1'b0;
      stopPend    <= 1'b0;
    end else begin
      if (ev.startDet)     busBusy <= 1'b1;
      else if (ev.stopDet) busBusy <= 1'b0;

      if (ev.startDet)  startIssued <= 1'b0;
      else if (startGo) startIssued <= 1'b1;

      if (lose || ev.stopDet)            owner <= 1'b0;
      else if (ev.startDet && startIssued) owner <= 1'b1;

      if (lose)            backOff <= 1'b1;
      else if (ev.stopDet) backOff <= 1'b0;

      flushReq <= lose;

      if (lose)           arbErr <= 1'b1;
      else if (arbErrClr) arbErr <= 1'b0;

      if (lose)         txLockout <= 1'b1;
      else if (lockClr) txLockout <= 1'b0;

      if (slaveSwitch)    masterMode <= 1'b0;
      else if (masterSet) masterMode <= 1'b1;

      if (clearReq)                     startPend <= 1'b0;
      else if (owner && ev.stopDet)     startPend <= 1'b0;
      else if (startSet && masterMode)  startPend <= 1'b1;

      if (clearReq)                      restartPend <= 1'b0;
      else if (owner && ev.startDet)     restartPend <= 1'b0;
      else if (restartSet && masterMode) restartPend <= 1'b1;

      if (clearReq)                   stopPend <= 1'b0;
      else if (owner && ev.stopDet)   stopPend <= 1'b0;
      else if (stopSet && masterMode) stopPend <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import i2c_arb_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int TIMER_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [ADDR_W-1:0]  ownAddr,
  input  logic [TIMER_W-1:0] sclLowTime,
  input  logic               mstTxActive,
  input  logic               mstSdaOut,
  input  logic               masterSet,
  input  logic               startSet,
  input  logic               restartSet,
  input  logic               stopSet,
  input  logic               arbErrClr,
  input  logic               lockClr,
  input  logic               txPush,
  output logic               txPushOk,
  output logic               busBusy,
  output logic               startGo,
  output logic               backOff,
  output logic               flushReq,
  output logic               arbErr,
  output logic               txLockout,
  output logic               masterMode,
  output logic               startPend,
  output logic               restartPend,
  output logic               stopPend
);

  busEv_t   ev;
  ctrlStb_t stb;

  i2c_arb_dp #(
    .ADDR_W(ADDR_W), .TIMER_W(TIMER_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .sclLowTime(sclLowTime),
    .mstTxActive(mstTxActive), .mstSdaOut(mstSdaOut),
    .stb(stb), .ev(ev)
  );

  i2c_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev),
    .masterSet(masterSet), .startSet(startSet), .restartSet(restartSet),
    .stopSet(stopSet), .arbErrClr(arbErrClr), .lockClr(lockClr),
    .txPush(txPush), .stb(stb), .txPushOk(txPushOk),
    .busBusy(busBusy), .startGo(startGo), .backOff(backOff),
    .flushReq(flushReq), .arbErr(arbErr), .txLockout(txLockout),
    .masterMode(masterMode), .startPend(startPend),
    .restartPend(restartPend), .stopPend(stopPend)
  );

endmodule

// File: rtl/i2c_arb_monitor_chk.sv
module i2c_arb_monitor_chk (
  input logic clk,
  input logic rstN,
  input logic lockClr,
  input logic txPushOk,
  input logic busBusy,
  input logic startGo,
  input logic backOff,
  input logic flushReq,
  input logic arbErr,
  input logic txLockout,
  input logic masterMode,
  input logic startPend,
  input logic restartPend,
  input logic stopPend
);

  // R3
  err_with_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbErr) |-> txLockout);

  // R5
  flush_clears_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> (!startPend && !restartPend && !stopPend && backOff));

  // R7
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    startGo |-> !busBusy);

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txLockout && !lockClr) |=> txLockout);

  // R8
  lock_blocks_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    txLockout |-> !txPushOk);

  // R6
  slave_drop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(masterMode) |-> !startPend);

endmodule

bind i2c_arb_monitor i2c_arb_monitor_chk u_chk (
  .clk(clk), .rstN(rstN), .lockClr(lockClr), .txPushOk(txPushOk),
  .busBusy(busBusy), .startGo(startGo), .backOff(backOff),
  .flushReq(flushReq), .arbErr(arbErr), .txLockout(txLockout),
  .masterMode(masterMode), .startPend(startPend),
  .restartPend(restartPend), .stopPend(stopPend)
);

// File: tb/i2c_arb_monitor_tb.sv
module i2c_arb_monitor_tb;

  localparam int LOWT = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1, sdaIn = 1'b1;
  logic [6:0] ownAddr = 7'h2A;
  logic [15:0] sclLowTime = 16'(LOWT);
  logic mstTxActive = 1'b0, mstSdaOut = 1'b1;
  logic masterSet = 1'b0, startSet = 1'b0, restartSet = 1'b0, stopSet = 1'b0;
  logic arbErrClr = 1'b0, lockClr = 1'b0, txPush = 1'b0;
  logic txPushOk, busBusy, startGo, backOff, flushReq, arbErr, txLockout;
  logic masterMode, startPend, restartPend, stopPend;

  int errors = 0, checks = 0, flushCnt = 0;
  bit lostB;

  always #10 clk = ~clk;

  i2c_arb_monitor u_dut (.*);

  always @(posedge clk) if (rstN && flushReq) flushCnt++;

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; wclk(1); s = 1'b0;
  endtask

  function automatic int firstLoss(logic [7:0] l, logic [7:0] o);
    for (int i = 7; i >= 0; i--) if (l[i] && !o[i]) return 7 - i;
    return -1;
  endfunction

  task automatic busStart();
    sdaIn = 1'b1; wclk(4); sclIn = 1'b1; wclk(4);
    sdaIn = 1'b0; wclk(4); sclIn = 1'b0; wclk(4);
  endtask

  task automatic busStop();
    sclIn = 1'b0; wclk(2); sdaIn = 1'b0; wclk(4);
    sclIn = 1'b1; wclk(4); sdaIn = 1'b1; wclk(6);
  endtask

  // Both masters on the line; wired-AND resolution.
  task automatic sendByte(logic [7:0] lb, logic [7:0] ob, bit localOn, bit otherOn);
    lostB = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sclIn = 1'b0;
      mstTxActive = localOn && !lostB;
      mstSdaOut = lb[i];
      sdaIn = (mstTxActive ? lb[i] : 1'b1) & (otherOn ? ob[i] : 1'b1);
      wclk(4);
      sclIn = 1'b1; wclk(5);
      if (mstTxActive && lb[i] && !sdaIn) lostB = 1'b1;
    end
    sclIn = 1'b0; mstTxActive = 1'b0; mstSdaOut = 1'b1; wclk(4);
  endtask

  task automatic waitGo(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (startGo) begin seen = 1'b1; break; end
      wclk(1);
    end
  endtask

  // Own a transfer: request START, wait for go, put START on the bus.
  task automatic claimBus();
    bit seen;
    if (!masterMode) pulse(masterSet);
    pulse(startSet);
    waitGo(seen);
    chk("R7 startGo when free", {31'd0, seen}, 32'd1);
    wclk(1);
    busStart();
  endtask

  task automatic arbCase(logic [7:0] lb, logic [7:0] ob, string tag);
    int f0;
    bit expLoss, expHit;
    claimBus();
    pulse(restartSet); pulse(stopSet);
    f0 = flushCnt;
    expLoss = (firstLoss(lb, ob) >= 0);
    expHit = expLoss && (ob[7:1] == ownAddr);
    sendByte(lb, ob, 1'b1, 1'b1);
    chk({"R3 arbErr ", tag}, {31'd0, arbErr}, {31'd0, expLoss});
    chk({"R3 lockout ", tag}, {31'd0, txLockout}, {31'd0, expLoss});
    chk({"R3 flush count ", tag}, flushCnt - f0, expLoss ? 1 : 0);
    chk({"R6 masterMode ", tag}, {31'd0, masterMode}, {31'd0, !expHit});
    if (expLoss) begin
      chk({"R5 requests cleared ", tag}, {29'd0, startPend, restartPend, stopPend}, 32'd0);
      chk({"R5 backOff ", tag}, {31'd0, backOff}, 32'd1);
    end else begin
      chk({"R5 requests kept ", tag}, {29'd0, startPend, restartPend, stopPend}, 32'd7);
    end
    busStop();
    chk({"R5 backOff after STOP ", tag}, {31'd0, backOff}, 32'd0);
    chk({"R10 startPend after STOP ", tag}, {31'd0, startPend}, 32'd0);
    chk({"R2 idle after STOP ", tag}, {31'd0, busBusy}, 32'd0);
    txPush = 1'b1; wclk(1);
    chk({"R8 push gate ", tag}, {31'd0, txPushOk}, {31'd0, !expLoss});
    txPush = 1'b0;
    pulse(arbErrClr); pulse(lockClr);
    wclk(1);
    chk({"R9 arbErr cleared ", tag}, {31'd0, arbErr}, 32'd0);
  endtask

  initial begin
    bit seen;
    int c;
    void'($urandom(32'd1234));
    wclk(3);
    rstN = 1'b1;
    wclk(2);
    // R1
    chk("R1 reset outputs",
        {21'd0, busBusy, startGo, backOff, flushReq, arbErr, txLockout,
         masterMode, startPend, restartPend, stopPend, txPushOk}, 32'd0);

    // R2: foreign transfer sets and clears busy.
    sdaIn = 1'b0; wclk(3);
    chk("R2 busy after START", {31'd0, busBusy}, 32'd1);
    sendByte(8'h00, 8'h55, 1'b0, 1'b1);
    sclIn = 1'b0; sdaIn = 1'b0; wclk(4); sclIn = 1'b1; wclk(4);
    sdaIn = 1'b1; wclk(3);
    chk("R2 idle after STOP", {31'd0, busBusy}, 32'd0);
    wclk(LOWT + 4);

    // R7: start requested while busy waits out the bus-free time.
    pulse(masterSet);
    busStart();
    pulse(startSet);
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin if (startGo) seen = 1'b1; wclk(1); end
    chk("R7 no go while busy", {31'd0, seen}, 32'd0);
    sclIn = 1'b0; wclk(2); sdaIn = 1'b0; wclk(4); sclIn = 1'b1; wclk(4);
    sdaIn = 1'b1;
    c = 0;
    for (int k = 0; k < 20 && busBusy; k++) wclk(1);
    while (!startGo && c < 200) begin wclk(1); c++; end
    chk("R7 bus-free wait length", c, LOWT);
    wclk(1);
    busStart();
    chk("R2 own START busy", {31'd0, busBusy}, 32'd1);

    // R10: repeated START by owner clears restartPend.
    pulse(restartSet);
    sendByte(8'hA4, 8'hFF, 1'b1, 1'b0);
    chk("R10 restartPend set", {31'd0, restartPend}, 32'd1);
    busStart();
    chk("R10 restartPend cleared by repeated START", {31'd0, restartPend}, 32'd0);
    chk("R10 startPend held during transfer", {31'd0, startPend}, 32'd1);
    // R4: local 0 against line 0, then not transmitting with mismatch.
    sendByte(8'h00, 8'h00, 1'b1, 1'b1);
    chk("R4 no loss on matching zeros", {31'd0, arbErr}, 32'd0);
    sendByte(8'hFF, 8'h00, 1'b0, 1'b1);
    chk("R4 no loss when not transmitting", {31'd0, arbErr}, 32'd0);
    busStop();
    chk("R10 startPend cleared after owned STOP", {31'd0, startPend}, 32'd0);

    // Directed loss cases.
    arbCase(8'hFF, 8'h30, "loss foreign addr");
    arbCase({ownAddr, 1'b1}, {ownAddr, 1'b0}, "R6 loss on R/W bit own addr");
    arbCase(8'hF0, {ownAddr, 1'b1}, "R6 early loss own addr");
    arbCase(8'h12, 8'h12, "R4 identical bytes");

    // Random pairs.
    for (int n = 0; n < 8; n++) begin
      logic [7:0] a, b;
      a = 8'($urandom());
      b = 8'($urandom());
      arbCase(a, b, $sformatf("random %0d", n));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule